// File: doc/BRIEF.md
# Paired Debug Trigger Fire Combiner

This block holds the settings of ten debug match triggers and turns the raw match bits from the comparators into final fire decisions. Software-side logic sends settings one trigger at a time. Each write is a valid-qualified beat that carries a trigger index, a 2-bit match kind, a select bit, a timing bit, an action bit, a chain bit and a 64-bit compare value. The stored settings are driven back out as flat buses so that the comparators elsewhere can use them.

The triggers work in fixed pairs. Trigger 2g and trigger 2g+1 form group g. When a group is chained, the pair fires only when both members match in the same cycle and both members ask for the same timing. An unchained trigger fires on its own raw match. The fire vector is split by timing into a trap-now flag (timing 0) and a trap-after-next-instruction flag (timing 1), and the two together form a global hit. A clear input masks every fire for the cycle in which it is high.

The block has no sequencing state. Its only state is the settings register bank, which has two conditions per slot: held and loaded-on-write. All fire logic is combinational from that bank and the current raw match vector.

Top module: `dbg_trig_combiner`

## Requirements
- R1: After reset every stored field of every trigger reads zero. So no group is chained, all timing bits are 0, and the compare value, kind, select and action outputs are all zero.
- R2: A write with `cfg_wr_vld` high loads all fields of the trigger named by `cfg_wr_idx` at that clock edge, and those fields are visible on the outputs from the next cycle. Every other trigger keeps its fields.
- R3: A write whose index is 10 or above changes no stored field.
- R4: Bits are numbered by trigger: bit i of `raw_hit`, `fire`, `cfg_tim_vec` and `cfg_chain_vec` belongs to trigger i. The compare value of trigger i sits at `cfg_cmp_flat[64*i +: 64]` and its kind at `cfg_kind_flat[2*i +: 2]`. An unchained trigger fires exactly when its raw match bit is 1.
- R5: A group is chained when the chain bit of its even member is 1. The chain bit of the odd member has no effect on firing.
- R6: In a chained group, neither member fires unless both raw match bits are 1. When both fire, they fire together.
- R7: In a chained group whose two members hold different timing bits, neither member fires, even when both match.
- R8: `trap_now` is 1 exactly when some firing trigger has timing 0. `trap_next` is 1 exactly when some firing trigger has timing 1.
- R9: `any_hit` is the OR of all fire bits.
- R10: While `clr` is 1, `fire`, `trap_now`, `trap_next` and `any_hit` are all 0, whatever the raw match bits are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr | input | 1 | Masks all fire outputs this cycle |
| cfg_wr_vld | input | 1 | Settings write strobe |
| cfg_wr_idx | input | 4 | Trigger index of the write |
| cfg_wr_kind | input | 2 | Match kind to store |
| cfg_wr_sel | input | 1 | Select bit to store |
| cfg_wr_tim | input | 1 | Timing bit to store (0 = trap now, 1 = trap after next) |
| cfg_wr_act | input | 1 | Action bit to store |
| cfg_wr_chain | input | 1 | Chain bit to store |
| cfg_wr_cmp | input | 64 | Compare value to store |
| raw_hit | input | 10 | Raw match bits from the comparators |
| fire | output | 10 | Final per-trigger fire bits |
| trap_now | output | 1 | A timing-0 trigger fired |
| trap_next | output | 1 | A timing-1 trigger fired |
| any_hit | output | 1 | Any trigger fired |
| cfg_cmp_flat | output | 640 | Stored compare values, 64 bits per trigger |
| cfg_kind_flat | output | 20 | Stored match kinds, 2 bits per trigger |
| cfg_sel_vec | output | 10 | Stored select bits |
| cfg_act_vec | output | 10 | Stored action bits |
| cfg_tim_vec | output | 10 | Stored timing bits |
| cfg_chain_vec | output | 10 | Stored chain bits |

## Verification
The bound checker checks several rules on every cycle: the clear masking, that no trigger fires without its raw match, that chained members fire together, that a timing mismatch silences a chained pair, the consistency of the two trap flags and the global hit with the fire vector, and that the stored settings stay still when no write happens. Other behaviour can only be shown by the bench's chosen scenarios. These include the exact fire pattern for each mix of groups, that only the addressed slot is loaded, that out-of-range indices are dropped, that the odd member's chain bit is ignored, and the cleared state after reset.

// File: rtl/trigc_pkg.sv
package trigc_pkg;

    // Control fields of one trigger slot (compare value is kept apart,
    // its width being a parameter of the bank).
    typedef struct packed {
        logic [1:0] kind;
        logic       sel;
        logic       tim;
        logic       act;
        logic       chain;
    } trig_ctl_t;

    localparam logic TIM_NOW  = 1'b0;
    localparam logic TIM_NEXT = 1'b1;

endpackage

// File: rtl/trigc_cfg_bank.sv
module trigc_cfg_bank
    import trigc_pkg::*;
#(
    parameter int NUM_TRIG = 10,
    parameter int CMP_W    = 64,
    parameter int IDX_W    = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_vld,
    input  logic [IDX_W-1:0]       wr_idx,
    input  trig_ctl_t              wr_ctl,
    input  logic [CMP_W-1:0]       wr_cmp,
    output trig_ctl_t              ctl_q [NUM_TRIG],
    output logic [CMP_W-1:0]       cmp_q [NUM_TRIG]
);

    // One register slot per trigger; a slot is either held or loaded.
    for (genvar s = 0; s < NUM_TRIG; s++) begin : g_slot
        logic       sel_me;
        trig_ctl_t  ctl_r;
        logic [CMP_W-1:0] cmp_r;

        assign sel_me = wr_vld && (wr_idx == IDX_W'(s));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ctl_r <= '0;
                cmp_r <= '0;
            end else if (sel_me) begin
                ctl_r <= wr_ctl;
                cmp_r <= wr_cmp;
            end
        end

        assign ctl_q[s] = ctl_r;
        assign cmp_q[s] = cmp_r;
    end

endmodule

// File: rtl/trigc_pair_fuse.sv
module trigc_pair_fuse (
    input  logic clr,
    input  logic chain_lo,
    input  logic tim_lo,
    input  logic tim_hi,
    input  logic hit_lo,
    input  logic hit_hi,
    output logic fire_lo,
    output logic fire_hi
);

    logic both_hit;
    logic tim_agree;
    logic pair_go;

    always_comb begin
        both_hit  = hit_lo && hit_hi;
        tim_agree = (tim_lo == tim_hi);
        pair_go   = both_hit && tim_agree;
        unique case (chain_lo)
            1'b1: begin
                fire_lo = pair_go;
                fire_hi = pair_go;
            end
            default: begin
                fire_lo = hit_lo;
                fire_hi = hit_hi;
            end
        endcase
        if (clr) begin
            fire_lo = 1'b0;
            fire_hi = 1'b0;
        end
    end

endmodule

// File: rtl/trigc_flag_reduce.sv
module trigc_flag_reduce #(
    parameter int NUM_TRIG = 10
) (
    input  logic [NUM_TRIG-1:0] fire,
    input  logic [NUM_TRIG-1:0] tim,
    output logic                trap_now,
    output logic                trap_next,
    output logic                any_hit
);

    always_comb begin
        trap_now  = |(fire & ~tim);
        trap_next = |(fire &  tim);
        any_hit   = trap_now | trap_next;
    end

endmodule

// File: rtl/dbg_trig_combiner.sv
module dbg_trig_combiner
    import trigc_pkg::*;
#(
    parameter int NUM_TRIG = 10,
    parameter int CMP_W    = 64,
    parameter int IDX_W    = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     cfg_wr_vld,
    input  logic [IDX_W-1:0]         cfg_wr_idx,
    input  logic [1:0]               cfg_wr_kind,
    input  logic                     cfg_wr_sel,
    input  logic                     cfg_wr_tim,
    input  logic                     cfg_wr_act,
    input  logic                     cfg_wr_chain,
    input  logic [CMP_W-1:0]         cfg_wr_cmp,
    input  logic [NUM_TRIG-1:0]      raw_hit,
    output logic [NUM_TRIG-1:0]      fire,
    output logic                     trap_now,
    output logic                     trap_next,
    output logic                     any_hit,
    output logic [NUM_TRIG*CMP_W-1:0] cfg_cmp_flat,
    output logic [NUM_TRIG*2-1:0]    cfg_kind_flat,
    output logic [NUM_TRIG-1:0]      cfg_sel_vec,
    output logic [NUM_TRIG-1:0]      cfg_act_vec,
    output logic [NUM_TRIG-1:0]      cfg_tim_vec,
    output logic [NUM_TRIG-1:0]      cfg_chain_vec
);

    localparam int NUM_GRP = NUM_TRIG / 2;

    trig_ctl_t        wr_ctl;
    trig_ctl_t        ctl_q [NUM_TRIG];
    logic [CMP_W-1:0] cmp_q [NUM_TRIG];

    always_comb begin
        wr_ctl.kind  = cfg_wr_kind;
        wr_ctl.sel   = cfg_wr_sel;
        wr_ctl.tim   = cfg_wr_tim;
        wr_ctl.act   = cfg_wr_act;
        wr_ctl.chain = cfg_wr_chain;
    end

    trigc_cfg_bank #(
        .NUM_TRIG (NUM_TRIG),
        .CMP_W    (CMP_W),
        .IDX_W    (IDX_W)
    ) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_vld (cfg_wr_vld),
        .wr_idx (cfg_wr_idx),
        .wr_ctl (wr_ctl),
        .wr_cmp (cfg_wr_cmp),
        .ctl_q  (ctl_q),
        .cmp_q  (cmp_q)
    );

    for (genvar t = 0; t < NUM_TRIG; t++) begin : g_flat
        assign cfg_cmp_flat[t*CMP_W +: CMP_W] = cmp_q[t];
        assign cfg_kind_flat[t*2 +: 2]        = ctl_q[t].kind;
        assign cfg_sel_vec[t]                 = ctl_q[t].sel;
        assign cfg_act_vec[t]                 = ctl_q[t].act;
        assign cfg_tim_vec[t]                 = ctl_q[t].tim;
        assign cfg_chain_vec[t]               = ctl_q[t].chain;
    end

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_pair
        trigc_pair_fuse u_fuse (
            .clr      (clr),
            .chain_lo (ctl_q[2*g].chain),
            .tim_lo   (ctl_q[2*g].tim),
            .tim_hi   (ctl_q[2*g+1].tim),
            .hit_lo   (raw_hit[2*g]),
            .hit_hi   (raw_hit[2*g+1]),
            .fire_lo  (fire[2*g]),
            .fire_hi  (fire[2*g+1])
        );
    end

    trigc_flag_reduce #(
        .NUM_TRIG (NUM_TRIG)
    ) u_reduce (
        .fire      (fire),
        .tim       (cfg_tim_vec),
        .trap_now  (trap_now),
        .trap_next (trap_next),
        .any_hit   (any_hit)
    );

endmodule

// File: rtl/trigc_checker.sv
module trigc_checker #(
    parameter int NUM_TRIG = 10,
    parameter int CMP_W    = 64
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      clr,
    input logic                      cfg_wr_vld,
    input logic [NUM_TRIG-1:0]       raw_hit,
    input logic [NUM_TRIG-1:0]       fire,
    input logic                      trap_now,
    input logic                      trap_next,
    input logic                      any_hit,
    input logic [NUM_TRIG*CMP_W-1:0] cfg_cmp_flat,
    input logic [NUM_TRIG-1:0]       cfg_tim_vec,
    input logic [NUM_TRIG-1:0]       cfg_chain_vec
);

    AST_CLR_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |-> (fire == '0) && !trap_now && !trap_next && !any_hit); // R10

    AST_FIRE_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (fire & ~raw_hit) == '0); // R4

    AST_ANY_IS_OR: assert property (@(posedge clk) disable iff (!rst_n)
        any_hit == (|fire)); // R9

    AST_NOW_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        trap_now == (|(fire & ~cfg_tim_vec))); // R8

    AST_NEXT_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        trap_next == (|(fire & cfg_tim_vec))); // R8

    AST_CFG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr_vld |=> $stable(cfg_cmp_flat) && $stable(cfg_tim_vec) && $stable(cfg_chain_vec)); // R2

    for (genvar g = 0; g < NUM_TRIG/2; g++) begin : g_grp
        AST_CHAIN_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_chain_vec[2*g] |-> (fire[2*g] == fire[2*g+1])); // R6

        AST_TIM_MISMATCH_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_chain_vec[2*g] && (cfg_tim_vec[2*g] != cfg_tim_vec[2*g+1]))
            |-> !fire[2*g] && !fire[2*g+1]); // R7
    end

endmodule

bind dbg_trig_combiner trigc_checker #(
    .NUM_TRIG (NUM_TRIG),
    .CMP_W    (CMP_W)
) u_trigc_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .clr           (clr),
    .cfg_wr_vld    (cfg_wr_vld),
    .raw_hit       (raw_hit),
    .fire          (fire),
    .trap_now      (trap_now),
    .trap_next     (trap_next),
    .any_hit       (any_hit),
    .cfg_cmp_flat  (cfg_cmp_flat),
    .cfg_tim_vec   (cfg_tim_vec),
    .cfg_chain_vec (cfg_chain_vec)
);

// File: tb/dbg_trig_combiner_test.sv
module dbg_trig_combiner_test;

    localparam int NT = 10;
    localparam int CW = 64;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            clr = 1'b0;
    logic            cfg_wr_vld = 1'b0;
    logic [3:0]      cfg_wr_idx = '0;
    logic [1:0]      cfg_wr_kind = '0;
    logic            cfg_wr_sel = 1'b0;
    logic            cfg_wr_tim = 1'b0;
    logic            cfg_wr_act = 1'b0;
    logic            cfg_wr_chain = 1'b0;
    logic [CW-1:0]   cfg_wr_cmp = '0;
    logic [NT-1:0]   raw_hit = '0;
    logic [NT-1:0]   fire;
    logic            trap_now, trap_next, any_hit;
    logic [NT*CW-1:0] cfg_cmp_flat;
    logic [NT*2-1:0] cfg_kind_flat;
    logic [NT-1:0]   cfg_sel_vec, cfg_act_vec, cfg_tim_vec, cfg_chain_vec;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dbg_trig_combiner uut (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .cfg_wr_vld(cfg_wr_vld), .cfg_wr_idx(cfg_wr_idx), .cfg_wr_kind(cfg_wr_kind),
        .cfg_wr_sel(cfg_wr_sel), .cfg_wr_tim(cfg_wr_tim), .cfg_wr_act(cfg_wr_act),
        .cfg_wr_chain(cfg_wr_chain), .cfg_wr_cmp(cfg_wr_cmp), .raw_hit(raw_hit),
        .fire(fire), .trap_now(trap_now), .trap_next(trap_next), .any_hit(any_hit),
        .cfg_cmp_flat(cfg_cmp_flat), .cfg_kind_flat(cfg_kind_flat),
        .cfg_sel_vec(cfg_sel_vec), .cfg_act_vec(cfg_act_vec),
        .cfg_tim_vec(cfg_tim_vec), .cfg_chain_vec(cfg_chain_vec)
    );

    // {raw_hit, clr, exp_fire, exp_now, exp_next}
    localparam logic [22:0] VEC [12] = '{
        {10'h001, 1'b0, 10'h000, 1'b0, 1'b0},  // R6 chained, one member only
        {10'h003, 1'b0, 10'h003, 1'b1, 1'b0},  // R6 chained, both members
        {10'h00C, 1'b0, 10'h000, 1'b0, 1'b0},  // R7 timing mismatch
        {10'h010, 1'b0, 10'h010, 1'b0, 1'b1},  // R4 unchained timing 1
        {10'h020, 1'b0, 10'h020, 1'b1, 1'b0},  // R4 unchained timing 0
        {10'h080, 1'b0, 10'h080, 1'b1, 1'b0},  // R5 odd chain bit ignored
        {10'h040, 1'b0, 10'h040, 1'b1, 1'b0},  // R5 even member alone
        {10'h100, 1'b0, 10'h000, 1'b0, 1'b0},  // R6 chained timing 1, one
        {10'h300, 1'b0, 10'h300, 1'b0, 1'b1},  // R8 chained timing 1, both
        {10'h3FF, 1'b0, 10'h3F3, 1'b1, 1'b1},  // R8 all raw
        {10'h3FF, 1'b1, 10'h000, 1'b0, 1'b0},  // R10 clear
        {10'h000, 1'b0, 10'h000, 1'b0, 1'b0}   // R9 idle
    };

    task automatic chk(input string req, input logic [NT*CW-1:0] act, input logic [NT*CW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] idx, input logic tim, input logic chain, input logic [CW-1:0] val);
        @(negedge clk);
        cfg_wr_vld   = 1'b1;
        cfg_wr_idx   = idx;
        cfg_wr_kind  = idx[1:0];
        cfg_wr_sel   = idx[0];
        cfg_wr_act   = idx[1];
        cfg_wr_tim   = tim;
        cfg_wr_chain = chain;
        cfg_wr_cmp   = val;
        @(posedge clk);
        #1;
        cfg_wr_vld = 1'b0;
    endtask

    task automatic apply(input logic [NT-1:0] r, input logic c);
        @(negedge clk);
        raw_hit = r;
        clr = c;
        #2;
    endtask

    function automatic logic [NT*CW-1:0] exp_cmp();
        logic [NT*CW-1:0] v = '0;
        for (int i = 0; i < NT; i++) v[i*CW +: CW] = 64'h1000 + 64'(i);
        return v;
    endfunction

    initial begin
        #(20 * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: cleared state after reset
        chk("R1 cmp", cfg_cmp_flat, '0);
        chk("R1 chain", {630'b0, cfg_chain_vec}, '0);
        chk("R1 tim", {630'b0, cfg_tim_vec}, '0);
        chk("R1 kind/sel/act", {610'b0, cfg_kind_flat, cfg_sel_vec, cfg_act_vec}, '0);
        apply(10'h3FF, 1'b0);
        chk("R1 unchained fire", {630'b0, fire}, {630'b0, 10'h3FF});
        chk("R1 flags", {637'b0, trap_now, trap_next, any_hit}, {637'b0, 3'b101});

        // Settings: chain, timing per trigger
        wr(4'd0, 1'b0, 1'b1, 64'h1000);
        wr(4'd1, 1'b0, 1'b0, 64'h1001);
        wr(4'd2, 1'b0, 1'b1, 64'h1002);
        wr(4'd3, 1'b1, 1'b0, 64'h1003);
        wr(4'd4, 1'b1, 1'b0, 64'h1004);
        wr(4'd5, 1'b0, 1'b0, 64'h1005);
        wr(4'd6, 1'b0, 1'b0, 64'h1006);
        wr(4'd7, 1'b0, 1'b1, 64'h1007);
        wr(4'd8, 1'b1, 1'b1, 64'h1008);
        wr(4'd9, 1'b1, 1'b0, 64'h1009);

        // R2: every slot holds its own write
        chk("R2 cmp values", cfg_cmp_flat, exp_cmp());
        chk("R2 kind of 6", {638'b0, cfg_kind_flat[12 +: 2]}, {638'b0, 2'd2});
        chk("R2 sel vec", {630'b0, cfg_sel_vec}, {630'b0, 10'b10_1010_1010});
        chk("R2 act vec", {630'b0, cfg_act_vec}, {630'b0, 10'b00_1100_1100});
        chk("R2 tim vec", {630'b0, cfg_tim_vec}, {630'b0, 10'b11_0001_1000});

        // R3: out-of-range indices change nothing
        wr(4'd10, 1'b1, 1'b1, 64'hFFFF);
        wr(4'd15, 1'b1, 1'b1, 64'hEEEE);
        chk("R3 cmp kept", cfg_cmp_flat, exp_cmp());
        chk("R3 chain kept", {630'b0, cfg_chain_vec}, {630'b0, 10'b01_1000_0101});

        // Vector table
        for (int k = 0; k < 12; k++) begin
            apply(VEC[k][22:13], VEC[k][12]);
            chk($sformatf("R4-table %0d fire", k), {630'b0, fire}, {630'b0, VEC[k][11:2]});
            chk($sformatf("R8 table %0d flags", k), {638'b0, trap_now, trap_next},
                {638'b0, VEC[k][1:0]});
            chk($sformatf("R9 table %0d any", k), {639'b0, any_hit},
                {639'b0, |VEC[k][11:2]});
        end

        // R7: make pair 0 disagree on timing
        wr(4'd1, 1'b1, 1'b0, 64'h1001);
        apply(10'h003, 1'b0);
        chk("R7 pair0 mismatch", {630'b0, fire}, '0);
        // R6/R8: pair 0 agrees again, both timing 1
        wr(4'd0, 1'b1, 1'b1, 64'h1000);
        apply(10'h003, 1'b0);
        chk("R6 pair0 agree", {630'b0, fire}, {630'b0, 10'h003});
        chk("R8 pair0 next", {638'b0, trap_now, trap_next}, {638'b0, 2'b01});
        // R2: rewrite of one slot leaves the others intact
        chk("R2 after rewrites", cfg_cmp_flat, exp_cmp());
        // R10: clear with a single unchained hit
        apply(10'h020, 1'b1);
        chk("R10 clear single", {636'b0, fire[3:0], trap_now, trap_next, any_hit, fire[5]}, '0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule